// File: doc/BRIEF.md
# Plug-and-play card configuration controller

This block runs the card-level side of the plug-and-play configuration protocol of a PC expansion bus. It tracks four protocol states and decodes host I/O traffic on three ports. The address port (write-only, 0x0279) selects a register index. The write-data port (write-only, 0x0A79) writes the selected register. The read-data port is read-only and its location is set by software. The controller holds the card select number, the logical device pointer and the read port location. It carries out the self-clearing card commands and answers register reads. Accesses to the per-device register window are forwarded to external register files through an index, data and strobe interface.

The initiation key is recognised elsewhere and arrives as a single-cycle pulse. The serial identifier is modelled as a counter of isolation reads. That counter returns a fixed alternating byte pair until the read budget of one card is used up. Resource data comes from an external source through a ready flag and a data byte.

Host strobes are one clock cycle wide. Register state changes on the clock edge that closes a write strobe. Read data, `rd_hit_o`, `res_rd_o`, `dev_wr_o` and `dev_defaults_o` are combinational during the strobe cycle.

Top module: `pnp_card_ctrl`

## Requirements
- R1: After reset, `state_o` is 0, `csn_o` is 0, `ldn_o` is 0 and the read port is unset. State codes are 0 wait-for-key, 1 sleep, 2 isolation and 3 configuration.
- R2: In wait-for-key, all port writes and reads are ignored, and `rd_hit_o` stays low. Only a `key_ok_i` pulse leaves this state, and it moves the card to sleep on the next cycle.
- R3: Outside wait-for-key, a write to 0x0279 stores the register index. Writes to 0x0A79 act on that index, and it stays selected for any number of data accesses.
- R4: The read port answers at address {6'b0, P, 2'b11}, where P is the 8-bit value of register 0x00, only when P bit 7 is 1 and only in isolation or configuration. Register 0x00 is writable only in isolation. When no port answers, `io_rdata_o` is 0.
- R5: A write to register 0x03 whose data equals the CSN moves the card to isolation when the data is 0 and to configuration otherwise, and it restarts the isolation read count. A mismatching write moves the card from isolation or configuration to sleep, and leaves it in sleep if it is already there.
- R6: In isolation, reads of register 0x01 return 0x55 after an even number of earlier reads and 0xAA after an odd number. After ISO_READS (72) reads they return 0 and `iso_done_o` is high.
- R7: A write to register 0x06 in isolation sets the CSN and enters configuration. In configuration it sets the CSN. In other states it is ignored. The register reads back only in configuration.
- R8: Register 0x07 is written only in configuration. Values of N_LD (5) or more are ignored. The value drives `ldn_o` and reads back in configuration.
- R9: Register 0x02 holds no state and reads 0. Writing it in any awake state acts on three bits: bit 2 clears the CSN and the read port, bit 1 returns to wait-for-key and keeps the CSN, and bit 0 raises `dev_defaults_o` during the write cycle.
- R10: In configuration, register 0x05 reads {7'b0, `res_rdy_i`}. Register 0x04 reads `res_data_i`, with `res_rd_o` high, only while `res_rdy_i` is 1; otherwise it reads 0 and `res_rd_o` stays low.
- R11: Indices 0x30 to 0x74 form the device window. In configuration, writes raise `dev_wr_o`, with `reg_idx_o` and `dev_wdata_o` valid, and reads return `dev_rdata_i`.
- R12: Index 0x75 reads 4. All other indices without a register read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| key_ok_i | input | 1 | Initiation key recognised (pulse) |
| io_addr_i | input | 16 | Host I/O address |
| io_wdata_i | input | 8 | Host write data |
| io_wr_i | input | 1 | Host I/O write strobe |
| io_rd_i | input | 1 | Host I/O read strobe |
| res_rdy_i | input | 1 | Next resource byte available |
| res_data_i | input | 8 | Resource byte |
| dev_rdata_i | input | 8 | Read data from device register files |
| io_rdata_o | output | 8 | Read-port data |
| rd_hit_o | output | 1 | Read port addressed and active |
| res_rd_o | output | 1 | Resource byte consumed |
| state_o | output | 2 | Protocol state |
| csn_o | output | 8 | Card select number |
| ldn_o | output | LDW | Selected logical device |
| reg_idx_o | output | 8 | Selected register index |
| dev_wr_o | output | 1 | Device window write strobe |
| dev_wdata_o | output | 8 | Device window write data |
| dev_defaults_o | output | 1 | Restore device defaults (pulse) |
| iso_done_o | output | 1 | Isolation read budget used up |

## Verification
Some properties are checked on every cycle:
- the card leaves wait-for-key only on a key pulse and then goes to sleep;
- the read port location changes only in isolation or by the clear command;
- the CSN is zero after a clear command;
- the device pointer stays in range;
- the isolation count only steps by one or restarts, and never passes its limit;
- no read data appears without a port hit.

The bench scenarios cover the rest:
- wake matching against the CSN in each state;
- the alternating isolation pattern and its exhaustion;
- the access rules for each index per state;
- the resource ready gating;
- the command pulses.

// File: rtl/pnp_pkg.sv
package pnp_pkg;
  typedef enum logic [1:0] {
    ST_WFK   = 2'd0,
    ST_SLEEP = 2'd1,
    ST_ISO   = 2'd2,
    ST_CFG   = 2'd3
  } pnp_state_e;

  localparam logic [15:0] ADDR_PORT  = 16'h0279;
  localparam logic [15:0] WDATA_PORT = 16'h0A79;

  localparam logic [7:0] IX_RDP    = 8'h00;
  localparam logic [7:0] IX_ISO    = 8'h01;
  localparam logic [7:0] IX_CTRL   = 8'h02;
  localparam logic [7:0] IX_WAKE   = 8'h03;
  localparam logic [7:0] IX_RES    = 8'h04;
  localparam logic [7:0] IX_STAT   = 8'h05;
  localparam logic [7:0] IX_CSN    = 8'h06;
  localparam logic [7:0] IX_LDN    = 8'h07;
  localparam logic [7:0] IX_DEV_LO = 8'h30;
  localparam logic [7:0] IX_DEV_HI = 8'h74;
  localparam logic [7:0] IX_FIXED  = 8'h75;
  localparam logic [7:0] FIXED_VAL = 8'h04;

  localparam logic [7:0] ISO_EVEN = 8'h55;
  localparam logic [7:0] ISO_ODD  = 8'hAA;

  // control register command bits
  localparam int CMD_DEFAULTS = 0;
  localparam int CMD_TO_WFK   = 1;
  localparam int CMD_CLR_CSN  = 2;
endpackage

// File: rtl/pnp_port_dec.sv
module pnp_port_dec
  import pnp_pkg::*;
(
  input  logic [15:0] addr_i,
  input  logic        wr_i,
  input  logic        rd_i,
  input  pnp_state_e  state_i,
  input  logic [7:0]  rdp_i,
  output logic        addr_wr_o,
  output logic        data_wr_o,
  output logic        rd_hit_o
);
  logic        awake;
  logic        rd_open;
  logic [15:0] rd_port;

  assign awake   = (state_i != ST_WFK);
  assign rd_open = (state_i == ST_ISO) || (state_i == ST_CFG);
  assign rd_port = {6'b0, rdp_i, 2'b11};

  assign addr_wr_o = wr_i && awake && (addr_i == ADDR_PORT);
  assign data_wr_o = wr_i && awake && (addr_i == WDATA_PORT);
  // bit 7 set keeps the port inside 0x203..0x3FF
  assign rd_hit_o  = rd_i && rd_open && rdp_i[7] && (addr_i == rd_port);
endmodule

// File: rtl/pnp_card_fsm.sv
module pnp_card_fsm
  import pnp_pkg::*;
#(
  parameter int ISO_READS = 72,
  localparam int CW = $clog2(ISO_READS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          key_ok_i,
  input  logic          data_wr_i,
  input  logic [7:0]    idx_i,
  input  logic [7:0]    wdata_i,
  input  logic [7:0]    csn_i,
  input  logic          iso_rd_i,
  output pnp_state_e    state_o,
  output logic [CW-1:0] iso_cnt_o
);
  pnp_state_e    state_q, state_d;
  logic [CW-1:0] iso_cnt_q;
  logic          wake_wr, wake_match;

  assign wake_wr    = data_wr_i && (idx_i == IX_WAKE);
  assign wake_match = wake_wr && (wdata_i == csn_i);

  always_comb begin
    state_d = state_q;
    if (state_q == ST_WFK) begin
      if (key_ok_i) state_d = ST_SLEEP;
    end else if (data_wr_i) begin
      unique case (idx_i)
        IX_WAKE: begin
          if (wdata_i == csn_i)       state_d = (wdata_i == 8'd0) ? ST_ISO : ST_CFG;
          else if (state_q != ST_SLEEP) state_d = ST_SLEEP;
        end
        IX_CSN:  if (state_q == ST_ISO) state_d = ST_CFG;
        IX_CTRL: if (wdata_i[CMD_TO_WFK]) state_d = ST_WFK;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_WFK;
      iso_cnt_q <= '0;
    end else begin
      state_q <= state_d;
      if (wake_match)
        iso_cnt_q <= '0;
      else if (iso_rd_i && state_q == ST_ISO && iso_cnt_q < CW'(ISO_READS))
        iso_cnt_q <= iso_cnt_q + 1'b1;
    end
  end

  assign state_o   = state_q;
  assign iso_cnt_o = iso_cnt_q;

  AST_WFK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WFK && !key_ok_i) |=> state_q == ST_WFK); // R2
  AST_KEY_TO_SLEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WFK && key_ok_i) |=> state_q == ST_SLEEP); // R2
  AST_ISO_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iso_cnt_q <= CW'(ISO_READS)); // R6
  AST_ISO_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iso_cnt_q != $past(iso_cnt_q)) |-> (iso_cnt_q == '0 || iso_cnt_q == $past(iso_cnt_q) + 1'b1)); // R6
endmodule

// File: rtl/pnp_card_regs.sv
module pnp_card_regs
  import pnp_pkg::*;
#(
  parameter int N_LD      = 5,
  parameter int ISO_READS = 72,
  localparam int LDW = (N_LD > 1) ? $clog2(N_LD) : 1,
  localparam int CW  = $clog2(ISO_READS + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  pnp_state_e     state_i,
  input  logic           addr_wr_i,
  input  logic           data_wr_i,
  input  logic           rd_hit_i,
  input  logic [7:0]     wdata_i,
  input  logic           res_rdy_i,
  input  logic [7:0]     res_data_i,
  input  logic [7:0]     dev_rdata_i,
  input  logic [CW-1:0]  iso_cnt_i,
  output logic [7:0]     idx_o,
  output logic [7:0]     csn_o,
  output logic [7:0]     rdp_o,
  output logic [LDW-1:0] ldn_o,
  output logic [7:0]     rdata_o,
  output logic           res_rd_o,
  output logic           dev_wr_o,
  output logic           dev_defaults_o
);
  logic [7:0]     idx_q, csn_q, rdp_q;
  logic [LDW-1:0] ldn_q;
  logic           in_cfg, in_iso, in_dev, clr_cmd;

  assign in_cfg  = (state_i == ST_CFG);
  assign in_iso  = (state_i == ST_ISO);
  assign in_dev  = (idx_q >= IX_DEV_LO) && (idx_q <= IX_DEV_HI);
  assign clr_cmd = data_wr_i && (idx_q == IX_CTRL) && wdata_i[CMD_CLR_CSN];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      csn_q <= '0;
      rdp_q <= '0;
      ldn_q <= '0;
    end else begin
      if (addr_wr_i) idx_q <= wdata_i;
      if (clr_cmd) begin
        csn_q <= '0;
        rdp_q <= '0;
      end else if (data_wr_i) begin
        if (idx_q == IX_RDP && in_iso) rdp_q <= wdata_i;
        if (idx_q == IX_CSN && (in_iso || in_cfg)) csn_q <= wdata_i;
        if (idx_q == IX_LDN && in_cfg && int'(wdata_i) < N_LD) ldn_q <= wdata_i[LDW-1:0];
      end
    end
  end

  assign dev_wr_o       = data_wr_i && in_cfg && in_dev;
  assign dev_defaults_o = data_wr_i && (idx_q == IX_CTRL) && wdata_i[CMD_DEFAULTS];
  assign res_rd_o       = rd_hit_i && (idx_q == IX_RES) && in_cfg && res_rdy_i;

  always_comb begin
    rdata_o = '0;
    if (rd_hit_i) begin
      unique case (idx_q)
        IX_ISO:   if (in_iso && iso_cnt_i < CW'(ISO_READS))
                    rdata_o = iso_cnt_i[0] ? ISO_ODD : ISO_EVEN;
        IX_RES:   if (in_cfg && res_rdy_i) rdata_o = res_data_i;
        IX_STAT:  if (in_cfg) rdata_o = {7'b0, res_rdy_i};
        IX_CSN:   if (in_cfg) rdata_o = csn_q;
        IX_LDN:   if (in_cfg) rdata_o = 8'(ldn_q);
        IX_FIXED: rdata_o = FIXED_VAL;
        default:  if (in_cfg && in_dev) rdata_o = dev_rdata_i;
      endcase
    end
  end

  assign idx_o = idx_q;
  assign csn_o = csn_q;
  assign rdp_o = rdp_q;
  assign ldn_o = ldn_q;

  AST_RDP_GUARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdp_q != $past(rdp_q)) |-> ($past(state_i) == ST_ISO || rdp_q == 8'd0)); // R4
  AST_RD_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_hit_i |-> rdata_o == 8'd0); // R4
  AST_CSN_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_cmd |=> csn_q == 8'd0); // R9
  AST_LDN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(ldn_q) < N_LD); // R8
endmodule

// File: rtl/pnp_card_ctrl.sv
module pnp_card_ctrl
  import pnp_pkg::*;
#(
  parameter int N_LD      = 5,
  parameter int ISO_READS = 72,
  localparam int LDW = (N_LD > 1) ? $clog2(N_LD) : 1,
  localparam int CW  = $clog2(ISO_READS + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           key_ok_i,
  input  logic [15:0]    io_addr_i,
  input  logic [7:0]     io_wdata_i,
  input  logic           io_wr_i,
  input  logic           io_rd_i,
  input  logic           res_rdy_i,
  input  logic [7:0]     res_data_i,
  input  logic [7:0]     dev_rdata_i,
  output logic [7:0]     io_rdata_o,
  output logic           rd_hit_o,
  output logic           res_rd_o,
  output logic [1:0]     state_o,
  output logic [7:0]     csn_o,
  output logic [LDW-1:0] ldn_o,
  output logic [7:0]     reg_idx_o,
  output logic           dev_wr_o,
  output logic [7:0]     dev_wdata_o,
  output logic           dev_defaults_o,
  output logic           iso_done_o
);
  pnp_state_e    state;
  logic [7:0]    idx, csn, rdp;
  logic [CW-1:0] iso_cnt;
  logic          addr_wr, data_wr, rd_hit;

  pnp_port_dec u_dec (
    .addr_i    (io_addr_i),
    .wr_i      (io_wr_i),
    .rd_i      (io_rd_i),
    .state_i   (state),
    .rdp_i     (rdp),
    .addr_wr_o (addr_wr),
    .data_wr_o (data_wr),
    .rd_hit_o  (rd_hit)
  );

  pnp_card_fsm #(.ISO_READS(ISO_READS)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .key_ok_i  (key_ok_i),
    .data_wr_i (data_wr),
    .idx_i     (idx),
    .wdata_i   (io_wdata_i),
    .csn_i     (csn),
    .iso_rd_i  (rd_hit && idx == IX_ISO),
    .state_o   (state),
    .iso_cnt_o (iso_cnt)
  );

  pnp_card_regs #(.N_LD(N_LD), .ISO_READS(ISO_READS)) u_regs (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .state_i        (state),
    .addr_wr_i      (addr_wr),
    .data_wr_i      (data_wr),
    .rd_hit_i       (rd_hit),
    .wdata_i        (io_wdata_i),
    .res_rdy_i      (res_rdy_i),
    .res_data_i     (res_data_i),
    .dev_rdata_i    (dev_rdata_i),
    .iso_cnt_i      (iso_cnt),
    .idx_o          (idx),
    .csn_o          (csn),
    .rdp_o          (rdp),
    .ldn_o          (ldn_o),
    .rdata_o        (io_rdata_o),
    .res_rd_o       (res_rd_o),
    .dev_wr_o       (dev_wr_o),
    .dev_defaults_o (dev_defaults_o)
  );

  assign rd_hit_o    = rd_hit;
  assign state_o     = state;
  assign csn_o       = csn;
  assign reg_idx_o   = idx;
  assign dev_wdata_o = io_wdata_i;
  assign iso_done_o  = (iso_cnt == CW'(ISO_READS));
endmodule

// File: tb/pnp_card_ctrl_tb.sv
`timescale 1ns/1ps
module pnp_card_ctrl_tb;
  localparam int NLD = 5;
  localparam int ISO_N = 72;
  localparam int RP = 16'h0203;
  localparam int AP = 16'h0279;
  localparam int WP = 16'h0A79;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        key_ok = 1'b0;
  logic [15:0] io_addr = '0;
  logic [7:0]  io_wdata = '0;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic        res_rdy = 1'b0;
  logic [7:0]  res_data = 8'hC7;
  logic [7:0]  dev_rdata = 8'h3C;
  logic [7:0]  io_rdata;
  logic        rd_hit, res_rd, dev_wr, dev_def, iso_done;
  logic [1:0]  state;
  logic [7:0]  csn, reg_idx, dev_wdata;
  logic [2:0]  ldn;

  always #2 clk = ~clk;

  pnp_card_ctrl #(.N_LD(NLD), .ISO_READS(ISO_N)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .key_ok_i(key_ok), .io_addr_i(io_addr),
    .io_wdata_i(io_wdata), .io_wr_i(io_wr), .io_rd_i(io_rd), .res_rdy_i(res_rdy),
    .res_data_i(res_data), .dev_rdata_i(dev_rdata), .io_rdata_o(io_rdata),
    .rd_hit_o(rd_hit), .res_rd_o(res_rd), .state_o(state), .csn_o(csn),
    .ldn_o(ldn), .reg_idx_o(reg_idx), .dev_wr_o(dev_wr), .dev_wdata_o(dev_wdata),
    .dev_defaults_o(dev_def), .iso_done_o(iso_done)
  );

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  int m_state, m_csn, m_rdp, m_ldn, m_idx, m_iso;

  task automatic chk(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void m_reset();
    m_state = 0; m_csn = 0; m_rdp = 0; m_ldn = 0; m_idx = 0; m_iso = 0;
  endfunction

  function automatic int e_hit(int a);
    return (m_state >= 2 && m_rdp >= 128 && a == m_rdp * 4 + 3) ? 1 : 0;
  endfunction

  function automatic int e_rd(int a);
    if (e_hit(a) == 0) return 0;
    case (m_idx)
      1: return (m_state == 2 && m_iso < ISO_N) ? ((m_iso % 2) ? 8'hAA : 8'h55) : 0;
      4: return (m_state == 3 && res_rdy) ? int'(res_data) : 0;
      5: return (m_state == 3) ? int'(res_rdy) : 0;
      6: return (m_state == 3) ? m_csn : 0;
      7: return (m_state == 3) ? m_ldn : 0;
      8'h75: return 4;
      default: return (m_state == 3 && m_idx >= 8'h30 && m_idx <= 8'h74) ? int'(dev_rdata) : 0;
    endcase
  endfunction

  function automatic void m_wr(int a, int d);
    if (m_state == 0) return;
    if (a == AP) m_idx = d;
    else if (a == WP) begin
      case (m_idx)
        0: if (m_state == 2) m_rdp = d;
        2: begin
          if (d & 4) begin m_csn = 0; m_rdp = 0; end
          if (d & 2) m_state = 0;
        end
        3: if (d == m_csn) begin m_state = (d == 0) ? 2 : 3; m_iso = 0; end
           else if (m_state != 1) m_state = 1;
        6: if (m_state == 2) begin m_csn = d; m_state = 3; end
           else if (m_state == 3) m_csn = d;
        7: if (m_state == 3 && d < NLD) m_ldn = d;
        default: ;
      endcase
    end
  endfunction

  // per-cycle comparison with the reference model
  always @(negedge clk) if (rst_n && !done) begin
    chk("R5 state track", int'(state), m_state);
    chk("R7 csn track", int'(csn), m_csn);
    chk("R8 ldn track", int'(ldn), m_ldn);
    chk("R6 iso_done track", int'(iso_done), (m_iso == ISO_N) ? 1 : 0);
  end

  task automatic do_reset();
    rst_n = 1'b0; m_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic wr(int a, int d);
    int e_dev, e_def;
    e_dev = (m_state == 3 && a == WP && m_idx >= 8'h30 && m_idx <= 8'h74) ? 1 : 0;
    e_def = (m_state != 0 && a == WP && m_idx == 2 && (d & 1)) ? 1 : 0;
    io_addr = 16'(a); io_wdata = 8'(d); io_wr = 1'b1;
    #1;
    chk("R11 dev_wr", int'(dev_wr), e_dev);
    chk("R9 dev_defaults", int'(dev_def), e_def);
    if (e_dev != 0) begin
      chk("R11 reg_idx", int'(reg_idx), m_idx);
      chk("R11 dev_wdata", int'(dev_wdata), d);
    end
    @(posedge clk);
    m_wr(a, d);
    #1 io_wr = 1'b0;
  endtask

  task automatic rd(int a, string tag);
    int e_rr;
    io_addr = 16'(a); io_rd = 1'b1;
    #1;
    e_rr = (e_hit(a) != 0 && m_idx == 4 && m_state == 3 && res_rdy) ? 1 : 0;
    chk(tag, int'(io_rdata), e_rd(a));
    chk({tag, " hit"}, int'(rd_hit), e_hit(a));
    chk("R10 res_rd", int'(res_rd), e_rr);
    @(posedge clk);
    if (e_hit(a) != 0 && m_idx == 1 && m_state == 2 && m_iso < ISO_N) m_iso++;
    #1 io_rd = 1'b0;
  endtask

  task automatic sel(int ix);
    wr(AP, ix);
  endtask

  task automatic key();
    key_ok = 1'b1;
    @(posedge clk);
    if (m_state == 0) m_state = 1;
    #1 key_ok = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    do_reset();
    chk("R1 reset state", int'(state), 0);
    chk("R1 reset csn", int'(csn), 0);
    chk("R1 reset ldn", int'(ldn), 0);
    rd(RP, "R1 no read port");

    // wait-for-key ignores traffic
    sel(6); wr(WP, 8'h12);
    chk("R2 wfk ignores writes", int'(state), 0);
    rd(RP, "R2 wfk read silent");
    key();
    @(negedge clk);
    chk("R2 key to sleep", int'(state), 1);

    // wake mismatch stays asleep, match with 0 enters isolation
    sel(3); wr(WP, 5);
    chk("R5 sleep mismatch", int'(state), 1);
    wr(WP, 0);
    chk("R5 wake to iso", int'(state), 2);

    sel(0); wr(WP, 8'h80);
    sel(1);
    for (int i = 0; i < ISO_N; i++) rd(RP, "R6 iso pattern R3 index kept");
    rd(RP, "R6 exhausted");
    rd(RP, "R6 exhausted again");
    chk("R6 iso_done", int'(iso_done), 1);
    rd(RP + 4, "R4 wrong port");

    sel(6); wr(WP, 8'h2A);
    chk("R7 csn in iso", int'(csn), 8'h2A);
    chk("R7 iso to cfg", int'(state), 3);

    sel(0); wr(WP, 8'h81);
    sel(6); rd(RP, "R4 port kept in cfg"); rd(RP + 4, "R4 relocation refused");

    sel(7); wr(WP, 2); rd(RP, "R8 ldn read");
    wr(WP, 7); rd(RP, "R8 ldn clamp");
    chk("R8 ldn port", int'(ldn), 2);

    sel(8'h30); wr(WP, 8'h11); rd(RP, "R11 dev read");
    sel(8'h74); wr(WP, 8'h22); rd(RP, "R11 dev high edge");
    sel(8'h75); rd(RP, "R12 fixed four");
    sel(8'h20); rd(RP, "R12 unimplemented");
    sel(8'h76); rd(RP, "R12 above window");
    sel(2); rd(RP, "R9 ctrl reads zero");

    sel(5); res_rdy = 1'b0; rd(RP, "R10 status low");
    res_rdy = 1'b1; rd(RP, "R10 status high");
    sel(4); res_rdy = 1'b0; rd(RP, "R10 res not ready");
    res_rdy = 1'b1; rd(RP, "R10 res ready");
    res_rdy = 1'b0;

    sel(3); wr(WP, 8'h13);
    chk("R5 cfg mismatch to sleep", int'(state), 1);
    rd(RP, "R4 sleep silent");
    wr(WP, 8'h2A);
    chk("R5 match to cfg", int'(state), 3);

    sel(2); wr(WP, 1);
    chk("R9 defaults keeps state", int'(state), 3);
    wr(WP, 2);
    chk("R9 to wfk", int'(state), 0);
    chk("R9 csn kept", int'(csn), 8'h2A);
    rd(RP, "R2 wfk silent after cmd");
    key();
    sel(3); wr(WP, 8'h2A);
    chk("R5 rewake cfg", int'(state), 3);
    sel(2); wr(WP, 4);
    chk("R9 csn cleared", int'(csn), 0);
    sel(6); rd(RP, "R9 read port cleared");

    sel(3); wr(WP, 0);
    chk("R5 wake iso again", int'(state), 2);
    chk("R5 iso count restart", int'(iso_done), 0);
    sel(0); wr(WP, 8'h80);
    sel(1); rd(RP, "R5 pointer restart");
    rd(RP, "R6 second pattern");
    sel(3); wr(WP, 8'h44);
    chk("R5 iso mismatch sleep", int'(state), 1);
    sel(6); wr(WP, 8'h33);
    chk("R7 csn ignored in sleep", int'(csn), 0);

    do_reset();
    chk("R1 second reset state", int'(state), 0);
    chk("R1 second reset csn", int'(csn), 0);
    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule